// File: doc/BRIEF.md
# Rotating Systolic Partial-Product Multiplier

This block forms the raw partial-product columns of a 256 x 256 bit multiplication. Both operands are cut into sixteen 16-bit halfwords. Sixteen small 16 x 16 multipliers each feed a private 47-bit accumulator. For sixteen cycles one halfword of operand B is broadcast to every multiplier. The halfwords of operand A rotate one lane per cycle across the array, so lane x multiplies A halfword (t - x) mod 16 by B halfword 15 - t in cycle t.

Because of the rotation, each accumulator first gathers one of the upper columns 16..30. When its lane index is reached, that column is emitted on a single upper-column port and the accumulator restarts on one of the lower columns 0..15. These lower columns are all handed out together at the end. A downstream stage adds column k with weight 2^(16k) to form the 512-bit product. That carry resolution is not part of this block.

Top module: `ppm_array`

## Requirements
- R1: A start pulse is accepted only while the block is idle. Operands are captured on that edge. Halfword k of an operand is bits [16k+15:16k], so word w supplies halfword 2w from its low 16 bits and halfword 2w+1 from its high 16 bits.
- R2: After reset, `busy`, `up_vld` and `lo_vld` are low and every lower column reads zero.
- R3: Upper columns appear on `up_col` with `up_vld` high for fifteen consecutive cycles. The index `up_idx` falls from 30 to 16. The first one is visible after the second clock edge following the accepted start.
- R4: Column k, for k from 0 to 30, equals the exact sum of A_i x B_j over all i + j = k. Summing column k x 2^(16k) gives the full product A x B.
- R5: All sixteen lower columns are released together. `lo_vld` pulses for one cycle, in the same cycle as column 16 on the upper port. Column w sits at `lo_cols[47w+46:47w]`.
- R6: The lower columns hold their values while the block stays idle, until the next accepted start.
- R7: A start pulse that arrives while `busy` is high is ignored. The running multiply continues with its original operands.
- R8: `busy` is high for exactly sixteen cycles per multiply.
- R9: The accumulators never wrap. With all-ones operands, column 15 equals 16 x 65535^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply (honoured only while idle) |
| op_a | input | 256 | Operand A, rotated across the array |
| op_b | input | 256 | Operand B, broadcast one halfword per cycle |
| busy | output | 1 | Multiply in progress |
| up_vld | output | 1 | `up_col` carries an upper column |
| up_idx | output | 5 | Index of the column on `up_col` (16..30) |
| up_col | output | 47 | Upper partial column value |
| lo_vld | output | 1 | One-cycle strobe marking the release of the lower columns |
| lo_cols | output | 752 | Lower columns 0..15, 47 bits each |

## Verification
The operand patterns are zero, a single unit halfword in A, repeated word patterns, and mixed constants. The unit halfword shows whether B's halfwords land in the right columns, and so separates a correct halfword split from a swapped one. Repeated patterns place large values in every lane, so a wrong rotation direction or a wrong lane-to-column mapping changes the rebuilt product. The all-ones case drives the middle column to its maximum, which shows whether the accumulator is wide enough. A start injected mid-run shows whether the captured operands are protected.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  localparam int PPM_HW    = 16;
  localparam int PPM_NH    = 16;
  localparam int PPM_ACC_W = 47;

  // lane x starts with A halfword (NH - x) mod NH so that after t rotations it holds (t - x) mod NH
  function automatic int start_lane_src(input int x, input int nh);
    return (nh - x) % nh;
  endfunction

  // column emitted by accumulator t when it is drained in cycle t
  function automatic int drained_column(input int t, input int nh);
    return 2 * nh - 1 - t;
  endfunction
endpackage

// File: rtl/ppm_seq.sv
module ppm_seq #(
  parameter int NH = 16,
  localparam int CNT_W = $clog2(NH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] tcnt,
  output logic             load,
  output logic             last
);
  assign load = start && !busy;
  assign last = busy && (tcnt == CNT_W'(NH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (load) begin
      busy <= 1'b1;
      tcnt <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      tcnt <= tcnt + 1'b1;
    end
  end

  // R8: count advances by one every busy cycle
  a_r8_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> tcnt == $past(tcnt) + 1'b1);
  // R7: a start during a run does not restart the count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !last |=> busy && tcnt != '0);
endmodule

// File: rtl/ppm_shifter.sv
module ppm_shifter
  import ppm_pkg::*;
#(
  parameter int HW = 16,
  parameter int NH = 16,
  localparam int OP_W = HW * NH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   step,
  input  logic [OP_W-1:0]        a_in,
  input  logic [OP_W-1:0]        b_in,
  output logic [NH-1:0][HW-1:0]  a_lane,
  output logic [HW-1:0]          b_bcast
);
  logic [NH-1:0][HW-1:0] b_q;

  for (genvar x = 0; x < NH; x++) begin : g_lane
    localparam int SRC  = start_lane_src(x, NH);
    localparam int PREV = (x + NH - 1) % NH;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    a_lane[x] <= '0;
      else if (load) a_lane[x] <= a_in[SRC*HW +: HW];
      else if (step) a_lane[x] <= a_lane[PREV];
    end
  end

  for (genvar k = 0; k < NH; k++) begin : g_b
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q[k] <= '0;
      else if (load) b_q[k] <= b_in[k*HW +: HW];
      else if (step) b_q[k] <= (k == 0) ? '0 : b_q[(k == 0) ? 0 : k-1];
    end
  end

  assign b_bcast = b_q[NH-1];
endmodule

// File: rtl/ppm_mac.sv
module ppm_mac #(
  parameter int HW    = 16,
  parameter int ACC_W = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             drain,
  input  logic [HW-1:0]    a_hw,
  input  logic [HW-1:0]    b_hw,
  output logic [ACC_W-1:0] acc
);
  logic [2*HW-1:0]  prod;
  logic [ACC_W-1:0] prod_ext;

  assign prod     = a_hw * b_hw;
  assign prod_ext = ACC_W'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (step)  acc <= drain ? prod_ext : acc + prod_ext;
  end

  // R9: accumulation never wraps
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    step && !drain && !clr |=> acc >= $past(acc));
endmodule

// File: rtl/ppm_array.sv
module ppm_array
  import ppm_pkg::*;
#(
  parameter int HW    = PPM_HW,
  parameter int NH    = PPM_NH,
  parameter int ACC_W = PPM_ACC_W,
  localparam int OP_W  = HW * NH,
  localparam int CNT_W = $clog2(NH),
  localparam int IDX_W = $clog2(2 * NH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  output logic                busy,
  output logic                up_vld,
  output logic [IDX_W-1:0]    up_idx,
  output logic [ACC_W-1:0]    up_col,
  output logic                lo_vld,
  output logic [NH*ACC_W-1:0] lo_cols
);
  logic [CNT_W-1:0]          tcnt;
  logic                      load, last;
  logic [NH-1:0][HW-1:0]     a_lane;
  logic [HW-1:0]             b_bcast;
  logic [NH-1:0][ACC_W-1:0]  acc_all;
  logic [NH-1:0]             drain_vec;

  ppm_seq #(.NH(NH)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .tcnt(tcnt), .load(load), .last(last)
  );

  ppm_shifter #(.HW(HW), .NH(NH)) shf_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(busy),
    .a_in(op_a), .b_in(op_b), .a_lane(a_lane), .b_bcast(b_bcast)
  );

  for (genvar x = 0; x < NH; x++) begin : g_cell
    assign drain_vec[x] = busy && (x != 0) && (tcnt == CNT_W'(x));
    ppm_mac #(.HW(HW), .ACC_W(ACC_W)) mac_i (
      .clk(clk), .rst_n(rst_n), .clr(load), .step(busy),
      .drain(drain_vec[x]), .a_hw(a_lane[x]), .b_hw(b_bcast),
      .acc(acc_all[x])
    );
    assign lo_cols[x*ACC_W +: ACC_W] = acc_all[NH-1-x];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_vld <= 1'b0;
      up_idx <= '0;
      up_col <= '0;
      lo_vld <= 1'b0;
    end else begin
      up_vld <= busy && (tcnt != '0);
      up_idx <= IDX_W'(drained_column(0, NH)) - IDX_W'(tcnt);
      up_col <= acc_all[tcnt];
      lo_vld <= last;
    end
  end

  // R1: broadcast starts at the top halfword of the captured B operand
  a_r1_first_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> b_bcast == $past(op_b[OP_W-1 -: HW]));
  // R3: upper columns leave in strictly falling order on consecutive cycles
  a_r3_upper_order: assert property (@(posedge clk) disable iff (!rst_n)
    up_vld && $past(up_vld) |-> up_idx == $past(up_idx) - 1'b1);
  // R5: lower release coincides with column NH on the upper port
  a_r5_lower_release: assert property (@(posedge clk) disable iff (!rst_n)
    lo_vld |-> up_vld && up_idx == IDX_W'(NH));
  // R6: lower columns hold while idle
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(lo_cols));
  // R8: only one drain per cycle
  a_r8_one_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain_vec));
endmodule

// File: tb/ppm_array_tb.sv
`timescale 1ns/1ps
module ppm_array_tb_top;
  localparam int HW = 16, NH = 16, AW = 47, OPW = 256, NV = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [OPW-1:0] op_a = '0, op_b = '0;
  logic busy, up_vld, lo_vld;
  logic [4:0] up_idx;
  logic [AW-1:0] up_col;
  logic [NH*AW-1:0] lo_cols;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ppm_array dut_i (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .up_vld(up_vld), .up_idx(up_idx), .up_col(up_col),
    .lo_vld(lo_vld), .lo_cols(lo_cols));

  localparam logic [OPW-1:0] VA [NV] = '{
    {OPW{1'b0}},
    256'd1,
    {8{32'hDEADBEEF}},
    {4{64'h0123456789ABCDEF}},
    {32'hFFFF0000, 32'h00010002, 32'h80000001, 32'h7FFFFFFF,
     32'h13579BDF, 32'h2468ACE0, 32'hF0F0F0F0, 32'h0000FFFF}};
  localparam logic [OPW-1:0] VB [NV] = '{
    {8{32'hCAFEF00D}},
    {4{64'hFEDCBA9876543210}},
    {8{32'h12345678}},
    {16{16'h8001}},
    {32'h00000001, 32'hFFFFFFFF, 32'h55AA55AA, 32'h10203040,
     32'h0F0F0F0F, 32'hFFFF0001, 32'h00008000, 32'hABCDEF01}};

  logic [AW-1:0] cols [2*NH-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [575:0] act, input logic [575:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit inject);
    int first_up, n_up, lo_cyc, n_busy, prev_idx;
    bit order_ok;
    logic [NH*AW-1:0] lo_save;
    logic [575:0] sum, expp;
    first_up = -1; n_up = 0; lo_cyc = -1; n_busy = 0; prev_idx = 31; order_ok = 1;
    lo_save = '0;
    @(negedge clk); start = 1'b1; op_a = a; op_b = b;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 26; cyc++) begin
      if (busy) n_busy++;
      if (up_vld) begin
        if (first_up < 0) first_up = cyc;
        if (int'(up_idx) != prev_idx - 1) order_ok = 0;
        prev_idx = int'(up_idx);
        if (up_idx >= 5'd16 && up_idx <= 5'd30) cols[up_idx] = up_col;
        n_up++;
      end
      if (lo_vld) begin
        lo_cyc = cyc;
        lo_save = lo_cols;
        chk(up_vld && up_idx == 5'd16, "R5", "release beside column 16", 576'(up_idx), 576'd16);
        for (int w = 0; w < NH; w++) cols[w] = lo_cols[w*AW +: AW];
      end
      if (inject && cyc == 5) begin start = 1'b1; op_a = ~a; op_b = ~b; end
      else start = 1'b0;
      @(negedge clk);
    end
    chk(first_up == 2, "R3", "first upper column cycle", 576'(first_up), 576'd2);
    chk(n_up == 15 && order_ok, "R3", "fifteen falling upper columns", 576'(n_up), 576'd15);
    chk(lo_cyc == 16, "R5", "lower release cycle", 576'(lo_cyc), 576'd16);
    chk(n_busy == 16, "R8", "busy length", 576'(n_busy), 576'd16);
    chk(lo_cols == lo_save, "R6", "lower columns held idle", 576'(lo_cols), 576'(lo_save));
    sum = '0;
    for (int k = 0; k < 2*NH-1; k++) sum += 576'(cols[k]) << (HW*k);
    expp = 576'(512'(a) * 512'(b));
    chk(sum == expp, inject ? "R7" : "R4", "rebuilt product R1", sum, expp);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !up_vld && !lo_vld, "R2", "control outputs after reset",
        576'({busy, up_vld, lo_vld}), 576'd0);
    chk(lo_cols == '0, "R2", "lower columns after reset", 576'(lo_cols), 576'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_op(VA[v], VB[v], 1'b0);
    // R7: start pulse during a run must be ignored
    run_op(VA[4], VB[4], 1'b1);
    // R9: all-ones operands fill the middle column to its maximum
    run_op({OPW{1'b1}}, {OPW{1'b1}}, 1'b0);
    chk(cols[15] == AW'(64'd16 * 64'd65535 * 64'd65535), "R9", "column 15 maximum",
        576'(cols[15]), 576'(64'd16 * 64'd65535 * 64'd65535));
    // R1: single halfword 1 of A set selects B shifted by one halfword
    run_op(256'h1_0000, VB[2], 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule